// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link: a bit clock, a frame clock whose level marks the channel on the line, and a data wire. It runs entirely in the bit-clock domain as a slave. It samples the data on each rising edge of the bit clock and rebuilds one two's complement word per channel slot. It hands each completed left/right pair to the parallel side through registered outputs with a single-cycle valid strobe.

A 3-bit format code selects the framing. Two framings place the most significant bit at the start of the slot: left-justified with no delay, and I2S with one bit clock of delay. The remaining four place the least significant bit on the last bit before the frame clock changes. In these right-justified framings the MSB position is counted back from the frame edge by the word length (16, 18, 20 or 24 bits). Every word leaves the block 24 bits wide.

Top module: `serial_audio_rx`

## Requirements
- R1: While the synchronous active-low reset is held at a clock edge, both output words go to zero and the valid strobe goes low.
- R2: Data is sampled on the bit clock's rising edge, MSB first. Format code 0 (left-justified) takes the bit sampled at the frame clock change as the MSB. A high frame clock marks the left channel.
- R3: Format code 1 (I2S) takes the MSB one bit clock after the frame clock change. A low frame clock marks the left channel. The last data bit may fall on the first sample of the next slot.
- R4: Format codes 2, 3, 4 and 5 are right-justified with words of 16, 24, 20 and 18 bits respectively. A high frame clock marks the left channel. The LSB is the last bit sampled before the frame clock changes. The word is sign-extended to 24 bits, and any bits earlier in the slot are ignored.
- R5: In codes 0 and 1, bits after the 24th data bit of a slot are ignored.
- R6: Frame lengths of 32, 48, 64, 96 and 128 bit clocks are accepted (slots of 16 to 64 bits). In codes 0 and 1, a slot shorter than 24 bits yields an MSB-aligned word whose unreceived low bits are zero. Right-justified codes need a slot at least as long as the word.
- R7: Each left slot followed by a right slot raises the valid strobe for exactly one cycle, in the cycle after the sample that ends the right slot, with both words updated together. The outputs hold their value at all other times.
- R8: A slot that did not begin at a frame clock change observed since reset is not captured. A right word without a captured left word before it produces no strobe.
- R9: Format codes 6 and 7 produce no strobe and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lrck | input | 1 | Frame clock; its level selects the channel on the data wire |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| fmt | input | 3 | Framing code 0 to 5; 6 and 7 are reserved |
| left_word | output | 24 | Last completed left sample |
| right_word | output | 24 | Last completed right sample |
| pair_valid | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
Every cycle, the checker confirms several properties. The strobe is never high in two consecutive cycles, and it only follows a change of the frame clock. The output words move only together with the strobe. Reserved codes never produce a strobe, and 16-bit right-justified words always arrive properly sign-extended. The bench scenarios are the only place where the actual bit placement is shown: left-justified and I2S alignment, right-justified windows at each word length, zero fill in short slots, discarded trailing and leading bits, and pairing when the stream starts on a right slot. These are covered by streaming known words at every supported frame length and comparing each presented pair with values computed from the format rules.

// File: rtl/sar_pkg.sv
// Package: shared format codes and helpers for the serial audio receiver.
// Assumes the format code is a 3-bit value; codes above 5 are reserved.
package sar_pkg;

    localparam logic [2:0] FMT_LJ   = 3'd0;
    localparam logic [2:0] FMT_I2S  = 3'd1;
    localparam logic [2:0] FMT_RJ16 = 3'd2;
    localparam logic [2:0] FMT_RJ24 = 3'd3;
    localparam logic [2:0] FMT_RJ20 = 3'd4;
    localparam logic [2:0] FMT_RJ18 = 3'd5;

    // True for a code that selects a defined framing.
    function automatic logic fmt_known(input logic [2:0] code);
        return code <= FMT_RJ18;
    endfunction

    // True for the right-justified framings.
    function automatic logic fmt_is_rj(input logic [2:0] code);
        return (code >= FMT_RJ16) && (code <= FMT_RJ18);
    endfunction

    // Word length of a right-justified framing; 24 for the others.
    function automatic int fmt_rj_width(input logic [2:0] code);
        case (code)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            FMT_RJ18: return 18;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/frame_tracker.sv
// Frame tracker: follows the frame clock, flags each change of level and
// counts samples inside the current slot. Assumes lrck is already in the
// bit-clock domain. The first sample after reset only primes the history,
// so no change is reported against an unknown earlier level.
module frame_tracker #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck,
    output logic             edge_hit,
    output logic             lr_prev,
    output logic             slot_live,
    output logic [IDX_W-1:0] bit_idx
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic primed;

    // Frame clock change against the previous sample.
    always_comb edge_hit = primed && (lrck != lr_prev);

    // History, slot validity and saturating in-slot sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            lr_prev   <= 1'b0;
            slot_live <= 1'b0;
            bit_idx   <= '0;
        end else begin
            primed  <= 1'b1;
            lr_prev <= lrck;
            if (edge_hit) begin
                slot_live <= 1'b1;
                bit_idx   <= IDX_W'(1);
            end else if (bit_idx != IDX_MAX) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/msb_capture.sv
// MSB-first capture: builds an MSB-aligned word from the start of a slot,
// with no delay (left-justified) or one bit clock of delay (I2S). Bits
// beyond the word width are dropped; unreceived low bits stay zero.
// word_done is meaningful only in the cycle edge_hit is high; for the
// delayed framing it folds in the bit sampled on that edge.
module msb_capture #(
    parameter int WORD_W = 24,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              edge_hit,
    input  logic              delayed,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [WORD_W-1:0] word_done
);

    logic [WORD_W-1:0] acc;
    logic [IDX_W-1:0]  pos;
    logic              pos_ok;

    // Data bit position of the current sample within the slot.
    always_comb begin
        pos    = bit_idx - IDX_W'(delayed);
        pos_ok = (bit_idx >= IDX_W'(delayed)) && (int'(pos) < WORD_W);
    end

    // Accumulate sampled bits at their MSB-first positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (edge_hit) begin
            acc <= delayed ? '0 : {sdata, {(WORD_W-1){1'b0}}};
        end else if (pos_ok) begin
            acc[WORD_W-1-int'(pos)] <= sdata;
        end
    end

    // Completed word, including a delayed last bit landing on the edge.
    always_comb begin
        word_done = acc;
        if (delayed && pos_ok) begin
            word_done[WORD_W-1-int'(pos)] = sdata;
        end
    end

endmodule

// File: rtl/lsb_window.sv
// LSB-anchored capture: keeps the most recent WORD_W samples so that, at a
// frame clock change, the bits just before it form a right-justified word.
// The selected width is sign-extended to WORD_W. Assumes the slot is at
// least as long as the chosen word.
module lsb_window #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic [2:0]        fmt,
    output logic [WORD_W-1:0] word_done
);

    import sar_pkg::*;

    logic [WORD_W-1:0] hist;
    int                width;

    // Shift every sample in; the oldest falls off the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[WORD_W-2:0], sdata};
        end
    end

    // Pick the word width and sign-extend from its top bit.
    always_comb begin
        width = fmt_rj_width(fmt);
        if (width > WORD_W) width = WORD_W;
        for (int b = 0; b < WORD_W; b++) begin
            word_done[b] = (b < width) ? hist[b] : hist[width-1];
        end
    end

endmodule

// File: rtl/pair_assembler.sv
// Pair assembler: on each captured slot, holds a left word until the
// following right word arrives, then presents both with a one-cycle strobe.
// A right word with no held left word is discarded.
module pair_assembler #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              is_left,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_valid
);

    logic [WORD_W-1:0] left_hold;
    logic              have_left;

    // Hold the left word, release the pair on the right word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold  <= '0;
            have_left  <= 1'b0;
            left_word  <= '0;
            right_word <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (take) begin
                if (is_left) begin
                    left_hold <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_word  <= left_hold;
                    right_word <= word;
                    pair_valid <= 1'b1;
                    have_left  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
// Serial audio receiver top: slave deserializer for stereo PCM on a
// bit clock / frame clock / data link, six selectable framings, 24-bit
// registered outputs with a pair strobe. Assumes lrck, sdata and fmt are
// launched on the falling bit clock edge and fmt is held during a stream.
module serial_audio_rx #(
    parameter int WORD_W   = 24,
    parameter int SLOT_MAX = 64
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              lrck,
    input  logic              sdata,
    input  logic [2:0]        fmt,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_valid
);

    import sar_pkg::*;

    localparam int IDX_W = $clog2(SLOT_MAX) + 1;

    logic              edge_hit;
    logic              lr_prev;
    logic              slot_live;
    logic [IDX_W-1:0]  bit_idx;
    logic              delayed;
    logic [WORD_W-1:0] msb_word;
    logic [WORD_W-1:0] lsb_word;
    logic [WORD_W-1:0] sel_word;
    logic              is_left;
    logic              take;

    // Framing decode: delay, channel polarity, word source, capture enable.
    always_comb begin
        delayed  = (fmt == FMT_I2S);
        is_left  = lr_prev ^ delayed;
        sel_word = fmt_is_rj(fmt) ? lsb_word : msb_word;
        take     = edge_hit && slot_live && fmt_known(fmt);
    end

    frame_tracker #(.IDX_W(IDX_W)) u_track (
        .clk       (bclk),
        .rst_n     (rst_n),
        .lrck      (lrck),
        .edge_hit  (edge_hit),
        .lr_prev   (lr_prev),
        .slot_live (slot_live),
        .bit_idx   (bit_idx)
    );

    msb_capture #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_msb (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .edge_hit  (edge_hit),
        .delayed   (delayed),
        .bit_idx   (bit_idx),
        .word_done (msb_word)
    );

    lsb_window #(.WORD_W(WORD_W)) u_lsb (
        .clk       (bclk),
        .rst_n     (rst_n),
        .sdata     (sdata),
        .fmt       (fmt),
        .word_done (lsb_word)
    );

    pair_assembler #(.WORD_W(WORD_W)) u_pair (
        .clk        (bclk),
        .rst_n      (rst_n),
        .take       (take),
        .is_left    (is_left),
        .word       (sel_word),
        .left_word  (left_word),
        .right_word (right_word),
        .pair_valid (pair_valid)
    );

endmodule

// File: rtl/sar_checker.sv
// Checker for the serial audio receiver, bound to every instance of the top.
// Observes ports only.
module sar_checker #(
    parameter int WORD_W = 24
) (
    input logic              bclk,
    input logic              rst_n,
    input logic              lrck,
    input logic [2:0]        fmt,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word,
    input logic              pair_valid
);

    // R7: the strobe lasts a single cycle.
    p_single_pulse_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7: outputs hold unless the strobe presents a new pair.
    p_hold_outputs_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_word) && $stable(right_word)));

    // R7: a strobe only follows a change of the frame clock.
    p_strobe_after_edge_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |-> ($past(lrck) != $past(lrck, 2)));

    // R9: reserved codes never present a pair.
    p_reserved_silent_r9: assert property (@(posedge bclk) disable iff (!rst_n)
        ($past(fmt) >= 3'd6) |-> !pair_valid);

    // R4: 16-bit right-justified words arrive sign-extended.
    p_rj16_sign_r4: assert property (@(posedge bclk) disable iff (!rst_n)
        (pair_valid && $past(fmt) == 3'd2) |->
        (((&left_word[WORD_W-1:15]) || !(|left_word[WORD_W-1:15])) &&
         ((&right_word[WORD_W-1:15]) || !(|right_word[WORD_W-1:15]))));

endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_serial_audio_rx.sv
// Bench: sweeps every framing over every frame length and streams computed
// words; compares presented pairs with values derived from the format rules.
module sim_serial_audio_rx;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [23:0] left_word, right_word;
    logic        pair_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam int PAIRS = 4;

    int          cur_fmt, cur_s, cur_skew;
    int          got;
    bit          mon_en = 0;
    logic [23:0] slot_val [0:15];

    always #2.5 bclk = ~bclk;

    serial_audio_rx u0 (
        .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata), .fmt(fmt),
        .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int rj_w(input int f);
        case (f)
            2: return 16;
            3: return 24;
            4: return 20;
            5: return 18;
            default: return 24;
        endcase
    endfunction

    // Expected output for a sent word under the current framing.
    function automatic logic [23:0] expect_of(input int f, input int s, input logic [23:0] v);
        logic [23:0] r;
        int n;
        if (f >= 2 && f <= 5) begin
            n = rj_w(f);
            for (int b = 0; b < 24; b++) r[b] = (b < n) ? v[b] : v[n-1];
        end else begin
            n = (s < 24) ? s : 24;
            r = v & (24'hFFFFFF << (24 - n));
        end
        return r;
    endfunction

    function automatic logic [23:0] val_at(input int s);
        if (s < 16) return slot_val[s];
        return 24'h0;
    endfunction

    // Data bit on the wire at stream cycle t.
    function automatic logic bit_at(input int t);
        int u, s, k, w;
        logic [23:0] v;
        if (cur_fmt >= 2 && cur_fmt <= 5) begin
            s = t / cur_s; k = t % cur_s; w = rj_w(cur_fmt); v = val_at(s);
            if (k >= cur_s - w) return v[w-1-(k-(cur_s-w))];
            return ~v[w-1];
        end
        u = (cur_fmt == 1) ? t - 1 : t;
        if (u < 0) return 1'b0;
        s = u / cur_s; k = u % cur_s; v = val_at(s);
        if (k < 24) return v[23-k];
        return k[0];
    endfunction

    // Frame clock level at stream cycle t (t < 0 is the lead-in).
    function automatic logic lr_at(input int t);
        int s;
        logic left_lvl, is_right;
        left_lvl = (cur_fmt == 1) ? 1'b0 : 1'b1;
        s = (t < 0) ? -1 : t / cur_s;
        if (s < cur_skew) is_right = (s >= 0) ? 1'b1 : (cur_skew == 0);
        else is_right = ((s - cur_skew) % 2) == 1;
        if (t < 0 && cur_skew != 0) is_right = 1'b0;
        return is_right ? ~left_lvl : left_lvl;
    endfunction

    // Monitor: compare every presented pair with the stream contents (R2-R7).
    always @(negedge bclk) begin
        if (mon_en && pair_valid) begin
            logic [23:0] el, er;
            el = expect_of(cur_fmt, cur_s, val_at(cur_skew + 2*got));
            er = expect_of(cur_fmt, cur_s, val_at(cur_skew + 2*got + 1));
            if (cur_fmt == 0) begin
                check(left_word == el, "R2 left", left_word, el);
                check(right_word == er, "R2 right", right_word, er);
            end else if (cur_fmt == 1) begin
                check(left_word == el, "R3 left", left_word, el);
                check(right_word == er, "R3 right", right_word, er);
            end else begin
                check(left_word == el, "R4 left", left_word, el);
                check(right_word == er, "R4 right", right_word, er);
            end
            got++;
        end
    end

    task automatic do_reset();
        @(negedge bclk);
        rst_n = 1'b0;
        lrck  = lr_at(-1);
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;
    endtask

    // One stream: reset, lead-in, skew slots, PAIRS pairs, closing slot.
    task automatic burst(input int f, input int ratio, input int skew, input int seed);
        int nslots;
        logic [23:0] before_l, before_r;
        cur_fmt = f; cur_s = ratio / 2; cur_skew = skew;
        for (int i = 0; i < 16; i++)
            slot_val[i] = 24'((i + 1) * 32'h9E3779 + seed * 32'h7F4A7C + f * 32'h1357);
        slot_val[skew]     = 24'h800000 ^ 24'(seed);
        slot_val[skew + 3] = 24'h7FFFFF;
        fmt = 3'(f);
        do_reset();
        before_l = left_word; before_r = right_word;
        got = 0;
        mon_en = 1;
        nslots = skew + 2*PAIRS + 1;
        for (int t = -3; t < nslots * cur_s + 1; t++) begin
            lrck  = lr_at(t);
            sdata = (t < 0) ? 1'b0 : bit_at(t);
            @(negedge bclk);
        end
        repeat (3) @(negedge bclk);
        mon_en = 0;
        if (f >= 6) begin
            check(got == 0, "R9 no strobe", 24'(got), 24'd0);
            check(left_word == before_l && right_word == before_r,
                  "R9 outputs unchanged", left_word, before_l);
        end else if (skew != 0) begin
            check(got == PAIRS, "R8 pair count with leading right slot", 24'(got), 24'(PAIRS));
        end else begin
            check(got == PAIRS, "R7 pair count", 24'(got), 24'(PAIRS));
        end
    endtask

    initial begin
        int ratios [5] = '{32, 48, 64, 96, 128};
        int seed = 1;
        repeat (4) @(negedge bclk);
        check(left_word == 24'h0 && right_word == 24'h0, "R1 reset words", left_word, 24'h0);
        check(pair_valid == 1'b0, "R1 reset strobe", 24'(pair_valid), 24'h0);
        rst_n = 1'b1;
        // R6 sweep: every framing at every frame length it supports (R5 via long slots).
        for (int f = 0; f < 6; f++) begin
            for (int r = 0; r < 5; r++) begin
                if (f >= 2 && ratios[r] / 2 < rj_w(f)) continue;
                burst(f, ratios[r], 0, seed);
                seed++;
            end
        end
        // R8: stream opening with a complete right slot.
        burst(0, 64, 1, 77);
        burst(1, 32, 1, 78);
        burst(3, 128, 1, 79);
        // R9: reserved codes.
        burst(6, 64, 0, 80);
        burst(7, 48, 0, 81);
        // R1: reset again after traffic.
        @(negedge bclk);
        rst_n = 1'b0;
        @(negedge bclk);
        check(left_word == 24'h0 && right_word == 24'h0, "R1 reset after traffic", left_word, 24'h0);
        check(pair_valid == 1'b0, "R1 reset strobe after traffic", 24'(pair_valid), 24'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule